// File: doc/BRIEF.md
# Interleaved Storage Controller with Segment Reconfiguration

This block sits between one CPU port, several channel ports and four independent storage banks. The data path is eight bytes wide. In the normal mode, consecutive doublewords fall on consecutive banks, so up to four accesses can be in flight at once. Each bank stays occupied for a fixed number of cycles after it is selected. A request aimed at an occupied bank waits without holding up requests to other banks. When several requesters want the same free bank in one cycle, any channel beats the CPU. Among the channels, a rotating order applies, and the channel that heads that order is chosen by configuration.

Physical storage comes in up to eight 1 MB segments. Each segment has an enable bit and a 3-bit code that names the 1 MB address window it answers. The segment map, the serial/interleaved mode select and the leading channel are all captured while reset is held. These settings are reported back on status pins, so a segment that has failed can be left out of the map at the next reset. An access that no enabled segment claims, or one that is not doubleword aligned, is answered with an error response and no bank is used.

Requests use valid/ready. A requester keeps `req_valid` and its fields stable until it sees `req_ready` high at a rising edge. `req_ready` is only high while `req_valid` is high, and each port has at most one acceptance per cycle. Responses carry no back-pressure: every accepted request returns exactly one `rsp_valid` pulse a fixed number of cycles later.

Top module: `isc_storage_ctrl`

## Requirements
- R1: In interleaved mode (`cfg_serial`=0 at reset), a request goes to bank `addr[4:3]`, which is the doubleword index modulo 4.
- R2: In serial mode (`cfg_serial`=1 at reset), a request goes to bank `addr[19:18]`, so each bank holds one contiguous quarter of a segment.
- R3: Once a bank is selected in cycle t, it is not selected again before cycle t+BUSY_CYC. It may be selected in cycle t+BUSY_CYC. Requests to other banks are still accepted while it is busy.
- R4: When a channel and the CPU (requester 0) both want the same free bank in one cycle, the channel is granted and the CPU waits.
- R5: Channel k is requester k+1. When several channels want the same free bank, the channel at or after the latched leading channel, counting upward and wrapping, is granted. A leading-channel value of NUM_CH or more is latched as 0.
- R6: An aligned address with all bits above bit 22 at zero is claimed by the enabled segment whose 3-bit code equals `addr[22:20]`. If several enabled segments match, the lowest-numbered one wins. Its number appears on `mem_seg` and `addr[19:3]` appears on `mem_off` of the chosen bank.
- R7: An address with nonzero `addr[2:0]`, with any bit above bit 22 set, or claimed by no enabled segment is accepted in the cycle it is presented and selects no bank. Its response has `rsp_err`=1 and `rsp_rdata`=0.
- R8: A request accepted in cycle t gives `rsp_valid` for one cycle in cycle t+BUSY_CYC. For a good read, `rsp_rdata` equals the chosen bank's `mem_rdata` in that cycle.
- R9: The configuration inputs are captured only while `rst` is high and are ignored at all other times. The status outputs show the captured values.
- R10: An accepted write drives `mem_we`=1 and the request's write data on the chosen bank. At most one bank is selected per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one bank-selection slot per cycle |
| rst | input | 1 | Synchronous reset, active high; configuration is captured while high |
| cfg_seg_en | input | 8 | Per-segment enable, bit s for segment s |
| cfg_seg_range | input | 24 | Per-segment 3-bit window code at bits [3s+2:3s] |
| cfg_serial | input | 1 | 1 selects serial mode, 0 selects four-way interleave |
| cfg_ch_first | input | CH_W | Channel that leads the channel priority order |
| stat_seg_en | output | 8 | Captured segment enables |
| stat_seg_range | output | 24 | Captured window codes |
| stat_serial | output | 1 | Captured mode |
| stat_ch_first | output | CH_W | Captured leading channel |
| req_valid | input | NUM_CH+1 | Request valid per requester, bit 0 is the CPU |
| req_ready | output | NUM_CH+1 | Request accepted this cycle |
| req_we | input | NUM_CH+1 | 1 for write, 0 for read |
| req_addr | input | (NUM_CH+1)*24 | Byte address per requester |
| req_wdata | input | (NUM_CH+1)*64 | Write doubleword per requester |
| rsp_valid | output | NUM_CH+1 | Response pulse per requester |
| rsp_err | output | NUM_CH+1 | Addressing error flag of the response |
| rsp_rdata | output | (NUM_CH+1)*64 | Read doubleword of the response |
| mem_valid | output | 4 | Bank selected this cycle |
| mem_we | output | 4 | Bank access is a write |
| mem_seg | output | 12 | Physical segment per bank |
| mem_off | output | 68 | Doubleword offset in the segment per bank |
| mem_wdata | output | 256 | Write data per bank |
| mem_rdata | input | 256 | Read data per bank, valid in the response cycle |

## Verification
The bound checker watches several properties on every cycle. It checks that no bank is reselected inside its busy window, using its own gap counters. It checks that each response pulse lands exactly BUSY_CYC cycles after the matching acceptance. It also checks that error responses carry zero data, that the status pins stay still outside reset, and that bank selections never outnumber acceptances. Some behaviours can only be shown by the directed scenarios, because they depend on which requester should have won or where an address should have landed. These are the bank chosen for each address in both modes, the channel-over-CPU and rotating-channel outcomes, the segment picked from a reprogrammed map with overlapping codes, and the read-back of written data.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int SEG_N          = 8;
  localparam int SEG_W          = 3;
  localparam int BANK_N         = 4;
  localparam int BANK_W         = 2;
  localparam int SEG_BYTES_LOG2 = 20;
  localparam int DW_LOG2        = 3;
  localparam int OFF_W          = SEG_BYTES_LOG2 - DW_LOG2;

  typedef struct packed {
    logic              err;
    logic [SEG_W-1:0]  seg;
    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  off;
  } isc_route_t;
endpackage

// File: rtl/isc_addr_map.sv
module isc_addr_map
  import isc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [SEG_N-1:0]       seg_en,
  input  logic [SEG_N*SEG_W-1:0] seg_range,
  input  logic                   serial,
  output isc_route_t             route
);
  localparam int HI_LSB = SEG_BYTES_LOG2 + SEG_W;

  logic [SEG_W-1:0] code;
  logic             above;
  logic             misal;
  logic [SEG_N-1:0] claim;

  assign code  = addr[HI_LSB-1:SEG_BYTES_LOG2];
  assign above = |addr[ADDR_W-1:HI_LSB];
  assign misal = |addr[DW_LOG2-1:0];

  for (genvar s = 0; s < SEG_N; s++) begin : g_claim
    assign claim[s] = seg_en[s] && (seg_range[s*SEG_W +: SEG_W] == code);
  end

  always_comb begin
    route.seg = '0;
    for (int s = SEG_N - 1; s >= 0; s--) begin
      if (claim[s]) route.seg = SEG_W'(s);
    end
    route.err  = above | misal | ~(|claim);
    route.off  = addr[SEG_BYTES_LOG2-1:DW_LOG2];
    route.bank = serial ? addr[SEG_BYTES_LOG2-1 -: BANK_W]
                        : addr[DW_LOG2 +: BANK_W];
  end
endmodule

// File: rtl/isc_bank_arb.sv
module isc_bank_arb #(
  parameter int NUM_CH   = 2,
  parameter int BUSY_CYC = 3,
  parameter int NREQ     = NUM_CH + 1,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] want,
  input  logic [CH_W-1:0] ch_first,
  output logic [NREQ-1:0] gnt
);
  localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC + 1) : 1;

  logic [CNT_W-1:0] cnt;
  logic             free;
  logic             found;

  assign free = (cnt == '0);

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    if (free) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (!found && (c >= int'(ch_first)) && want[c+1]) begin
          gnt[c+1] = 1'b1;
          found    = 1'b1;
        end
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (!found && (c < int'(ch_first)) && want[c+1]) begin
          gnt[c+1] = 1'b1;
          found    = 1'b1;
        end
      end
      if (!found && want[0]) gnt[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (|gnt) begin
      cnt <= CNT_W'(BUSY_CYC - 1);
    end else if (!free) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/isc_rsp_pipe.sv
module isc_rsp_pipe
  import isc_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_err,
  input  logic [BANK_W-1:0] in_bank,
  output logic              out_vld,
  output logic              out_err,
  output logic [BANK_W-1:0] out_bank
);
  logic [DEPTH-1:0]  vld;
  logic [DEPTH-1:0]  err;
  logic [BANK_W-1:0] bank [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      vld[0] <= in_vld;
      for (int k = 1; k < DEPTH; k++) vld[k] <= vld[k-1];
    end
  end

  always_ff @(posedge clk) begin
    err[0]  <= in_err;
    bank[0] <= in_bank;
    for (int k = 1; k < DEPTH; k++) begin
      err[k]  <= err[k-1];
      bank[k] <= bank[k-1];
    end
  end

  assign out_vld  = vld[DEPTH-1];
  assign out_err  = err[DEPTH-1];
  assign out_bank = bank[DEPTH-1];
endmodule

// File: rtl/isc_storage_ctrl.sv
module isc_storage_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int BUSY_CYC = 3,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 24,
  localparam int NREQ    = NUM_CH + 1,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SEG_N-1:0]         cfg_seg_en,
  input  logic [SEG_N*SEG_W-1:0]   cfg_seg_range,
  input  logic                     cfg_serial,
  input  logic [CH_W-1:0]          cfg_ch_first,
  output logic [SEG_N-1:0]         stat_seg_en,
  output logic [SEG_N*SEG_W-1:0]   stat_seg_range,
  output logic                     stat_serial,
  output logic [CH_W-1:0]          stat_ch_first,
  input  logic [NREQ-1:0]          req_valid,
  output logic [NREQ-1:0]          req_ready,
  input  logic [NREQ-1:0]          req_we,
  input  logic [NREQ*ADDR_W-1:0]   req_addr,
  input  logic [NREQ*DATA_W-1:0]   req_wdata,
  output logic [NREQ-1:0]          rsp_valid,
  output logic [NREQ-1:0]          rsp_err,
  output logic [NREQ*DATA_W-1:0]   rsp_rdata,
  output logic [BANK_N-1:0]        mem_valid,
  output logic [BANK_N-1:0]        mem_we,
  output logic [BANK_N*SEG_W-1:0]  mem_seg,
  output logic [BANK_N*OFF_W-1:0]  mem_off,
  output logic [BANK_N*DATA_W-1:0] mem_wdata,
  input  logic [BANK_N*DATA_W-1:0] mem_rdata
);
  // configuration captured while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_seg_en    <= cfg_seg_en;
      stat_seg_range <= cfg_seg_range;
      stat_serial    <= cfg_serial;
      stat_ch_first  <= (int'(cfg_ch_first) >= NUM_CH) ? '0 : cfg_ch_first;
    end
  end

  isc_route_t        route [NREQ];
  logic [NREQ-1:0]   want  [BANK_N];
  logic [NREQ-1:0]   gnt   [BANK_N];
  logic [BANK_W-1:0] rbank [NREQ];

  for (genvar r = 0; r < NREQ; r++) begin : g_req
    isc_addr_map #(.ADDR_W(ADDR_W)) i_map (
      .addr      (req_addr[r*ADDR_W +: ADDR_W]),
      .seg_en    (stat_seg_en),
      .seg_range (stat_seg_range),
      .serial    (stat_serial),
      .route     (route[r])
    );
  end

  always_comb begin
    for (int b = 0; b < BANK_N; b++) begin
      for (int r = 0; r < NREQ; r++) begin
        want[b][r] = req_valid[r] && !route[r].err && (route[r].bank == BANK_W'(b));
      end
    end
  end

  for (genvar b = 0; b < BANK_N; b++) begin : g_bank
    isc_bank_arb #(.NUM_CH(NUM_CH), .BUSY_CYC(BUSY_CYC)) i_arb (
      .clk      (clk),
      .rst      (rst),
      .want     (want[b]),
      .ch_first (stat_ch_first),
      .gnt      (gnt[b])
    );

    always_comb begin
      mem_valid[b]                  = |gnt[b];
      mem_we[b]                     = 1'b0;
      mem_seg[b*SEG_W +: SEG_W]     = '0;
      mem_off[b*OFF_W +: OFF_W]     = '0;
      mem_wdata[b*DATA_W +: DATA_W] = '0;
      for (int r = 0; r < NREQ; r++) begin
        if (gnt[b][r]) begin
          mem_we[b]                     = req_we[r];
          mem_seg[b*SEG_W +: SEG_W]     = route[r].seg;
          mem_off[b*OFF_W +: OFF_W]     = route[r].off;
          mem_wdata[b*DATA_W +: DATA_W] = req_wdata[r*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NREQ; r++) begin
      logic won;
      won = 1'b0;
      for (int b = 0; b < BANK_N; b++) won = won | gnt[b][r];
      req_ready[r] = (req_valid[r] && route[r].err) || won;
    end
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_rsp
    isc_rsp_pipe #(.DEPTH(BUSY_CYC)) i_pipe (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (req_valid[r] && req_ready[r]),
      .in_err   (route[r].err),
      .in_bank  (route[r].bank),
      .out_vld  (rsp_valid[r]),
      .out_err  (rsp_err[r]),
      .out_bank (rbank[r])
    );

    assign rsp_rdata[r*DATA_W +: DATA_W] = (rsp_valid[r] && !rsp_err[r])
        ? mem_rdata[int'(rbank[r])*DATA_W +: DATA_W] : '0;
  end
endmodule

// File: rtl/isc_checker.sv
module isc_checker
  import isc_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int BUSY_CYC = 3,
  parameter int DATA_W   = 64,
  localparam int NREQ    = NUM_CH + 1,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [SEG_N-1:0]       stat_seg_en,
  input logic [SEG_N*SEG_W-1:0] stat_seg_range,
  input logic                   stat_serial,
  input logic [CH_W-1:0]        stat_ch_first,
  input logic [NREQ-1:0]        req_valid,
  input logic [NREQ-1:0]        req_ready,
  input logic [NREQ-1:0]        rsp_valid,
  input logic [NREQ-1:0]        rsp_err,
  input logic [NREQ*DATA_W-1:0] rsp_rdata,
  input logic [BANK_N-1:0]      mem_valid
);
  localparam int GAP_W = $clog2(BUSY_CYC + 1) + 1;

  logic [GAP_W-1:0] gap [BANK_N];
  logic [NREQ-1:0]  sh  [BUSY_CYC];

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANK_N; b++) begin
      if (rst) gap[b] <= GAP_W'(BUSY_CYC);
      else if (mem_valid[b]) gap[b] <= GAP_W'(1);
      else if (gap[b] < GAP_W'(BUSY_CYC)) gap[b] <= gap[b] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < BUSY_CYC; k++) sh[k] <= '0;
    end else begin
      sh[0] <= req_valid & req_ready;
      for (int k = 1; k < BUSY_CYC; k++) sh[k] <= sh[k-1];
    end
  end

  for (genvar b = 0; b < BANK_N; b++) begin : g_bank_chk
    AST_BANK_GAP: assert property (@(posedge clk) disable iff (rst)
      mem_valid[b] |-> (gap[b] >= GAP_W'(BUSY_CYC))); // R3
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_req_chk
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
      rsp_valid[r] == sh[BUSY_CYC-1][r]); // R8
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid[r] && rsp_err[r]) |-> (rsp_rdata[r*DATA_W +: DATA_W] == '0)); // R7
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(stat_seg_en) && $stable(stat_seg_range)
              && $stable(stat_serial) && $stable(stat_ch_first))); // R9

  AST_SEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    $countones(mem_valid) <= $countones(req_valid & req_ready)); // R10
endmodule

bind isc_storage_ctrl isc_checker #(
  .NUM_CH   (NUM_CH),
  .BUSY_CYC (BUSY_CYC),
  .DATA_W   (DATA_W)
) i_chk (
  .clk            (clk),
  .rst            (rst),
  .stat_seg_en    (stat_seg_en),
  .stat_seg_range (stat_seg_range),
  .stat_serial    (stat_serial),
  .stat_ch_first  (stat_ch_first),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_err        (rsp_err),
  .rsp_rdata      (rsp_rdata),
  .mem_valid      (mem_valid)
);

// File: tb/test_isc_storage_ctrl.sv
`timescale 1ns/1ps
module test_isc_storage_ctrl;
  localparam int NCH  = 2;
  localparam int NR   = NCH + 1;
  localparam int BUSY = 3;
  localparam int DW   = 64;
  localparam int AW   = 24;
  localparam int OFFW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0]       cfg_seg_en = 8'h03;
  logic [23:0]      cfg_seg_range = 24'h000008;
  logic             cfg_serial = 1'b0;
  logic [0:0]       cfg_ch_first = 1'b0;
  logic [7:0]       stat_seg_en;
  logic [23:0]      stat_seg_range;
  logic             stat_serial;
  logic [0:0]       stat_ch_first;
  logic [NR-1:0]    req_valid = '0;
  logic [NR-1:0]    req_ready;
  logic [NR-1:0]    req_we = '0;
  logic [NR*AW-1:0] req_addr = '0;
  logic [NR*DW-1:0] req_wdata = '0;
  logic [NR-1:0]    rsp_valid;
  logic [NR-1:0]    rsp_err;
  logic [NR*DW-1:0] rsp_rdata;
  logic [3:0]       mem_valid;
  logic [3:0]       mem_we;
  logic [11:0]      mem_seg;
  logic [4*OFFW-1:0] mem_off;
  logic [4*DW-1:0]  mem_wdata;
  logic [4*DW-1:0]  mem_rdata;

  isc_storage_ctrl #(.NUM_CH(NCH), .BUSY_CYC(BUSY), .DATA_W(DW), .ADDR_W(AW)) i_isc_storage_ctrl (
    .clk(clk), .rst(rst),
    .cfg_seg_en(cfg_seg_en), .cfg_seg_range(cfg_seg_range),
    .cfg_serial(cfg_serial), .cfg_ch_first(cfg_ch_first),
    .stat_seg_en(stat_seg_en), .stat_seg_range(stat_seg_range),
    .stat_serial(stat_serial), .stat_ch_first(stat_ch_first),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_seg(mem_seg),
    .mem_off(mem_off), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // bank storage model: data for a selection is presented until the bank is next selected
  logic [63:0] bmem [2048];
  logic [10:0] lat  [4];
  always @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (mem_valid[b]) begin
        lat[b] <= {mem_seg[b*3 +: 3], mem_off[b*OFFW +: 8]};
        if (mem_we[b]) bmem[{mem_seg[b*3 +: 3], mem_off[b*OFFW +: 8]}] <= mem_wdata[b*DW +: DW];
      end
    end
  end
  for (genvar b = 0; b < 4; b++) begin : g_mrd
    assign mem_rdata[b*DW +: DW] = bmem[lat[b]];
  end

  int checks = 0;
  int failures = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic do_reset(input logic [7:0] en, input logic [23:0] rng, input logic ser, input logic [0:0] first);
    @(negedge clk);
    req_valid = '0;
    cfg_seg_en = en; cfg_seg_range = rng; cfg_serial = ser; cfg_ch_first = first;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input int r, input logic we, input logic [23:0] addr, input logic [63:0] wd);
    req_we[r] = we;
    req_addr[r*AW +: AW] = addr;
    req_wdata[r*DW +: DW] = wd;
    req_valid[r] = 1'b1;
  endtask

  task automatic access(input int r, input logic we, input logic [23:0] addr, input logic [63:0] wd,
                        input logic exp_err, input int exp_bank, input int exp_seg,
                        input logic [63:0] exp_rd, input string tag);
    int n;
    @(negedge clk);
    drive(r, we, addr, wd);
    #1;
    n = 0;
    while (!req_ready[r] && n < 40) begin
      @(negedge clk); #1; n++;
    end
    chk(req_ready[r], {tag, " R10 accept"}, 64'(req_ready[r]), 64'd1);
    if (exp_err) begin
      chk(mem_valid == 4'b0, "R7 no bank selected", 64'(mem_valid), 64'd0);
    end else begin
      chk(mem_valid == 4'(1 << exp_bank), {tag, " bank"}, 64'(mem_valid), 64'(1 << exp_bank));
      chk(mem_seg[exp_bank*3 +: 3] == 3'(exp_seg), "R6 segment", 64'(mem_seg[exp_bank*3 +: 3]), 64'(exp_seg));
      chk(mem_off[exp_bank*OFFW +: OFFW] == addr[19:3], "R6 offset",
          64'(mem_off[exp_bank*OFFW +: OFFW]), 64'(addr[19:3]));
      if (we) chk(mem_we[exp_bank] && mem_wdata[exp_bank*DW +: DW] == wd, "R10 write data",
                  mem_wdata[exp_bank*DW +: DW], wd);
    end
    @(posedge clk); #1;
    req_valid[r] = 1'b0;
    repeat (BUSY - 1) @(negedge clk);
    chk(!rsp_valid[r], "R8 no early response", 64'(rsp_valid[r]), 64'd0);
    @(negedge clk);
    chk(rsp_valid[r], "R8 response cycle", 64'(rsp_valid[r]), 64'd1);
    chk(rsp_err[r] == exp_err, "R7 error flag", 64'(rsp_err[r]), 64'(exp_err));
    if (!we || exp_err) chk(rsp_rdata[r*DW +: DW] == exp_rd, {tag, " R8 read data"}, rsp_rdata[r*DW +: DW], exp_rd);
  endtask

  task automatic t_reset_state();
    do_reset(8'h03, 24'h000008, 1'b0, 1'b0);
    #1;
    chk(rsp_valid == '0 && mem_valid == '0 && req_ready == '0, "R9 idle after reset",
        64'({rsp_valid, mem_valid, req_ready}), 64'd0);
    chk(stat_seg_en == 8'h03 && stat_seg_range == 24'h000008 && !stat_serial && stat_ch_first == 1'b0,
        "R9 status shows captured config", 64'({stat_seg_en, stat_seg_range}), 64'h03000008);
  endtask

  task automatic t_interleave();
    for (int i = 0; i < 5; i++)
      access(0, 1'b1, 24'(i * 8), 64'hA500 + 64'(i), 1'b0, i % 4, 0, 64'd0, "R1");
    access(0, 1'b0, 24'h000010, 64'd0, 1'b0, 2, 0, 64'hA502, "R1");
    access(1, 1'b0, 24'h000020, 64'd0, 1'b0, 0, 0, 64'hA504, "R1");
  endtask

  task automatic t_collide();
    @(negedge clk);
    drive(0, 1'b0, 24'h000000, 64'd0);
    drive(1, 1'b0, 24'h000020, 64'd0);
    #1;
    chk(req_ready[1], "R4 channel wins bank", 64'(req_ready[1]), 64'd1);
    chk(!req_ready[0], "R4 CPU waits", 64'(req_ready[0]), 64'd0);
    @(posedge clk); #1; req_valid[1] = 1'b0;
    @(negedge clk);
    drive(2, 1'b0, 24'h000008, 64'd0);
    #1;
    chk(!req_ready[0], "R3 busy cycle 1", 64'(req_ready[0]), 64'd0);
    chk(req_ready[2], "R3 other bank proceeds", 64'(req_ready[2]), 64'd1);
    @(posedge clk); #1; req_valid[2] = 1'b0;
    @(negedge clk); #1;
    chk(!req_ready[0], "R3 busy cycle 2", 64'(req_ready[0]), 64'd0);
    @(negedge clk); #1;
    chk(req_ready[0], "R3 free at busy end", 64'(req_ready[0]), 64'd1);
    @(posedge clk); #1; req_valid[0] = 1'b0;
    repeat (BUSY + 2) @(negedge clk);
  endtask

  task automatic t_order(input logic [0:0] first, input int winner);
    do_reset(8'h03, 24'h000008, 1'b0, first);
    @(negedge clk);
    drive(1, 1'b0, 24'h000010, 64'd0);
    drive(2, 1'b0, 24'h000030, 64'd0);
    #1;
    chk(req_ready[winner] && !req_ready[3 - winner], "R5 channel rotation winner",
        64'(req_ready), 64'(1 << winner));
    @(posedge clk); #1; req_valid = '0;
    repeat (BUSY + 2) @(negedge clk);
  endtask

  task automatic t_serial();
    do_reset(8'h03, 24'h000008, 1'b1, 1'b0);
    #1;
    chk(stat_serial, "R9 serial captured", 64'(stat_serial), 64'd1);
    access(0, 1'b1, 24'h000000, 64'h51, 1'b0, 0, 0, 64'd0, "R2");
    access(0, 1'b1, 24'h000008, 64'h52, 1'b0, 0, 0, 64'd0, "R2");
    access(1, 1'b1, 24'h040010, 64'h53, 1'b0, 1, 0, 64'd0, "R2");
    access(2, 1'b1, 24'h1C0008, 64'h54, 1'b0, 3, 1, 64'd0, "R2");
    access(0, 1'b0, 24'h000008, 64'd0, 1'b0, 0, 0, 64'h52, "R2");
  endtask

  task automatic t_segmap();
    logic [23:0] rng;
    rng = (24'd1 << 6) | (24'd2 << 9) | (24'd3 << 15) | (24'd3 << 18) | (24'd3 << 21);
    do_reset(8'b1100_1101, rng, 1'b0, 1'b0);
    access(0, 1'b1, 24'h100000, 64'h77, 1'b0, 0, 2, 64'd0, "R6");
    access(1, 1'b1, 24'h300008, 64'h88, 1'b0, 1, 6, 64'd0, "R6");
    access(2, 1'b1, 24'h200010, 64'h99, 1'b0, 2, 3, 64'd0, "R6");
    access(0, 1'b0, 24'h100000, 64'd0, 1'b0, 0, 2, 64'h77, "R6");
    access(0, 1'b0, 24'h300008, 64'd0, 1'b0, 1, 6, 64'h88, "R6");
    access(1, 1'b0, 24'h400000, 64'd0, 1'b1, 0, 0, 64'd0, "R7 unclaimed");
    access(2, 1'b0, 24'h800000, 64'd0, 1'b1, 0, 0, 64'd0, "R7 high bit");
    access(0, 1'b1, 24'h000004, 64'h1, 1'b1, 0, 0, 64'd0, "R7 misaligned");
  endtask

  task automatic t_cfg_hold();
    do_reset(8'h03, 24'h000008, 1'b0, 1'b0);
    @(negedge clk);
    cfg_seg_en = 8'h00; cfg_serial = 1'b1; cfg_ch_first = 1'b1; cfg_seg_range = 24'hFFFFFF;
    repeat (2) @(negedge clk);
    #1;
    chk(stat_seg_en == 8'h03 && !stat_serial && stat_ch_first == 1'b0 && stat_seg_range == 24'h000008,
        "R9 config ignored outside reset", 64'({stat_seg_en, stat_serial}), 64'h006);
    access(0, 1'b1, 24'h100008, 64'h3C, 1'b0, 1, 1, 64'd0, "R9 old map");
    cfg_seg_en = 8'h03; cfg_serial = 1'b0; cfg_ch_first = 1'b0; cfg_seg_range = 24'h000008;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_interleave();
    t_collide();
    t_order(1'b0, 1);
    t_order(1'b1, 2);
    t_serial();
    t_segmap();
    t_cfg_hold();
    finish_run();
  end
endmodule